// File: doc/BRIEF.md
# Indexed Register Window Port

This block lets a host reach a large per-channel register bank through only two directly addressed words. One word is a pointer. It holds a channel number and a register index. The other word is a data window. Any read or write of the data window lands on the bank entry that the pointer currently names. Software sets the pointer once and then streams accesses through the window. It can also retarget only the channel, or only the index, with a single partial write.

The host side is a plain synchronous register bus. It has a word address, 32-bit write data with four byte enables, and separate read and write strobes. Read data is combinational, so the host sees the result in the same cycle as the strobe. The bank is internal. It holds four channels of 64 words each, and every word is cleared by reset. The bus has no valid/ready handshake, because each access completes in one cycle and never back-pressures.

Top module: `idxwin_port`

## Requirements
- R1: After reset the pointer reads as zero and every bank entry of every channel (index 0 to 63) reads as zero through the data window.
- R2: The pointer is at word address 0. A read returns the channel in bits 1:0 and the 12-bit register index in bits 27:16. Bits 15:2 and 31:28 read as zero.
- R3: A pointer write updates the channel only when byte enable 0 is set. It updates index bits 7:0 only when byte enable 2 is set, and index bits 11:8 only when byte enable 3 is set. A field whose byte enable is clear keeps its value.
- R4: A write to the data window (word address 1) updates, in the selected entry, only the bytes whose enables are set. The new value is visible from the next cycle on.
- R5: A read of the data window returns the selected entry's contents combinationally, in the same cycle as the read strobe.
- R6: When the pointer index is 64 or above, data window reads return zero and data window writes change no bank entry.
- R7: A pointer write never changes the contents of any bank entry.
- R8: Each channel has its own storage. A write under one channel leaves the same index of every other channel unchanged.
- R9: Read data is zero when the read strobe is low or the word address is neither 0 nor 1. Writes to other word addresses change neither the pointer nor the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |

## Verification
The bench builds the block with its default parameters: four channels, 64 implemented indices, a 12-bit pointer index field and a 4-bit word address. The pointer field is wider than the bank, so indices 64 through 4095 can be reached. The bench probes them to show that out-of-range reads return zero and that out-of-range writes do not alias onto low entries. The 4-bit address also reaches unmapped words 2 to 15, where reads must return zero and writes must be ignored.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
  localparam int DATA_W        = 32;
  localparam int BE_W          = DATA_W / 8;
  localparam int CH_FIELD_W    = 2;
  localparam int IDX_FIELD_W   = 12;
  localparam int IDX_FIELD_LSB = 16;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_NONE = 2'd2
  } win_sel_e;

  // Decode a word address onto the two implemented words.
  function automatic win_sel_e decode_addr(input logic [31:0] word_addr);
    case (word_addr)
      32'd0:   decode_addr = SEL_PTR;
      32'd1:   decode_addr = SEL_DATA;
      default: decode_addr = SEL_NONE;
    endcase
  endfunction

  // Pack the pointer fields into their bus image.
  function automatic logic [DATA_W-1:0] ptr_image(
    input logic [CH_FIELD_W-1:0]  ch,
    input logic [IDX_FIELD_W-1:0] idx
  );
    logic [DATA_W-1:0] img;
    img = '0;
    img[CH_FIELD_W-1:0] = ch;
    img[IDX_FIELD_LSB +: IDX_FIELD_W] = idx;
    return img;
  endfunction
endpackage

// File: rtl/idxwin_ptr.sv
module idxwin_ptr
  import idxwin_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ch_we,
  input  logic                   idx_lo_we,
  input  logic                   idx_hi_we,
  input  logic [CH_FIELD_W-1:0]  ch_d,
  input  logic [IDX_FIELD_W-1:0] idx_d,
  output logic [CH_FIELD_W-1:0]  ch_q,
  output logic [IDX_FIELD_W-1:0] idx_q
);
  localparam int LO_W = 8;
  localparam int HI_W = IDX_FIELD_W - LO_W;

  // Channel field: lives in the low halfword, updated on its own.
  always_ff @(posedge clk) begin
    if (!rst_n)      ch_q <= '0;
    else if (ch_we)  ch_q <= ch_d;
  end

  // Index field: two independently enabled slices in the upper halfword.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      if (idx_lo_we) idx_q[LO_W-1:0]          <= idx_d[LO_W-1:0];
      if (idx_hi_we) idx_q[IDX_FIELD_W-1:LO_W] <= idx_d[IDX_FIELD_W-1:LO_W];
    end
  end

  // R3: a write that leaves the channel byte disabled keeps the channel.
  a_r3_ch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_we |=> $stable(ch_q));

  // R3: with neither index byte enabled the index is kept.
  a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_lo_we && !idx_hi_we) |=> $stable(idx_q));

  // R3: an enabled channel byte lands in the channel field.
  a_r3_ch_load: assert property (@(posedge clk) disable iff (!rst_n)
    ch_we |=> (ch_q == $past(ch_d)));

  initial begin
    if (HI_W <= 0) $error("index field must be wider than one byte");
  end
endmodule

// File: rtl/idxwin_chan_bank.sv
module idxwin_chan_bank
  import idxwin_pkg::*;
#(
  parameter int NUM_IDX = 64,
  localparam int IDX_W  = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BE_W-1:0]   be,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_IDX];

  // One write lane per byte, each with its own enable.
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int e = 0; e < NUM_IDX; e++) mem[e][8*b +: 8] <= 8'h00;
      end else if (we && be[b]) begin
        mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  // Asynchronous read port: no pipeline stage toward the host.
  assign rdata = mem[idx];

  // R4: a full-word write is stored in the addressed entry.
  a_r4_full_store: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (be == '1)) |=> (mem[$past(idx)] == $past(wdata)));

  // R7: with no write enable the previously addressed entry keeps its value.
  a_r7_entry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (mem[$past(idx)] == $past(rdata)));
endmodule

// File: rtl/idxwin_port.sv
module idxwin_port
  import idxwin_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_IDX = 64,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int IDX_W = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1;

  win_sel_e                sel;
  logic [CH_FIELD_W-1:0]   ptr_ch;
  logic [IDX_FIELD_W-1:0]  ptr_idx;
  logic                    ptr_wr;
  logic                    data_wr;
  logic                    idx_ok;
  logic                    ch_ok;
  logic [IDX_W-1:0]        loc_idx;
  logic [DATA_W-1:0]       chan_rd [NUM_CH];
  logic [DATA_W-1:0]       win_rd;

  assign sel     = decode_addr(32'(bus_addr));
  assign ptr_wr  = bus_wr && (sel == SEL_PTR);
  assign data_wr = bus_wr && (sel == SEL_DATA);

  idxwin_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_we     (ptr_wr && bus_be[0]),
    .idx_lo_we (ptr_wr && bus_be[2]),
    .idx_hi_we (ptr_wr && bus_be[3]),
    .ch_d      (bus_wdata[CH_FIELD_W-1:0]),
    .idx_d     (bus_wdata[IDX_FIELD_LSB +: IDX_FIELD_W]),
    .ch_q      (ptr_ch),
    .idx_q     (ptr_idx)
  );

  assign idx_ok  = (ptr_idx < IDX_FIELD_W'(NUM_IDX));
  assign ch_ok   = (32'(ptr_ch) < NUM_CH);
  assign loc_idx = ptr_idx[IDX_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    idxwin_chan_bank #(.NUM_IDX(NUM_IDX)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (data_wr && idx_ok && (32'(ptr_ch) == c)),
      .be    (bus_be),
      .idx   (loc_idx),
      .wdata (bus_wdata),
      .rdata (chan_rd[c])
    );
  end

  always_comb begin
    win_rd = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (32'(ptr_ch) == c) win_rd = chan_rd[c];
    end
    if (!idx_ok || !ch_ok) win_rd = '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_PTR:  bus_rdata = ptr_image(ptr_ch, ptr_idx);
        SEL_DATA: bus_rdata = win_rd;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2: reserved pointer bits always read as zero.
  a_r2_ptr_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == '0)) |-> ((bus_rdata[15:2] == '0) && (bus_rdata[31:28] == '0)));

  // R6: an out-of-range index yields zero on the window.
  a_r6_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (sel == SEL_DATA) && !idx_ok) |-> (bus_rdata == '0));

  // R9: idle bus returns zero.
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/idxwin_port_test.sv
module idxwin_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  // Bench-side model of the pointer and bank.
  logic [1:0]  m_ch;
  logic [11:0] m_idx;
  logic [31:0] mdl [4][64];

  always #2 clk = ~clk;

  idxwin_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Monitor: compares each read result against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      logic [31:0] e;
      string t;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard empty act=%h exp=none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1; bus_rd = 1'b0;
    if (a == 4'd0) begin
      if (be[0]) m_ch = d[1:0];
      if (be[2]) m_idx[7:0] = d[23:16];
      if (be[3]) m_idx[11:8] = d[27:24];
    end else if (a == 4'd1 && m_idx < 12'd64) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) mdl[m_ch][m_idx[5:0]][8*b +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    logic [31:0] e;
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0; bus_be = '0;
    if (a == 4'd0)      e = {4'h0, m_idx, 14'h0, m_ch};
    else if (a == 4'd1) e = (m_idx < 12'd64) ? mdl[m_ch][m_idx[5:0]] : 32'h0;
    else                e = 32'h0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic set_ptr(input int ch, input int idx);
    wr(4'd0, {4'h0, 12'(idx), 14'h0, 2'(ch)}, 4'hF);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_ch = '0; m_idx = '0;
    for (int c = 0; c < 4; c++) for (int i = 0; i < 64; i++) mdl[c][i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: pointer and whole bank are zero after reset
    rd(4'd0, "R1 ptr reset");
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 64; i++) begin
        set_ptr(c, i);
        rd(4'd1, "R1 bank reset");
      end

    // R2: field layout and reserved bits
    wr(4'd0, 32'hFFFF_FFFF, 4'hF);
    rd(4'd0, "R2 ptr layout all ones");
    wr(4'd0, 32'h0000_0000, 4'hF);
    rd(4'd0, "R2 ptr cleared");

    // R3: independent field updates
    set_ptr(2, 12'h123);
    wr(4'd0, 32'h0000_0001, 4'h1);
    rd(4'd0, "R3 channel only");
    wr(4'd0, 32'hFFAB_FFFE, 4'h4);
    rd(4'd0, "R3 index low byte only");
    wr(4'd0, 32'hF5FF_FFFF, 4'h8);
    rd(4'd0, "R3 index high slice only");
    wr(4'd0, 32'hFFFF_FFFF, 4'h2);
    rd(4'd0, "R3 byte1 changes nothing");

    // R4 / R5: full and partial data writes, read same cycle
    set_ptr(2, 5);
    wr(4'd1, 32'hA5A5_5A5A, 4'hF);
    rd(4'd1, "R4 R5 full word");
    wr(4'd1, 32'h1122_3344, 4'h2);
    rd(4'd1, "R4 byte1 merge");
    wr(4'd1, 32'h99AA_BBCC, 4'h9);
    rd(4'd1, "R4 bytes 0 and 3");
    wr(4'd1, 32'h7777_7777, 4'h0);
    rd(4'd1, "R4 no enables");

    // R8: other channels at same index untouched
    for (int c = 0; c < 4; c++) begin
      set_ptr(c, 5);
      rd(4'd1, "R8 channel isolation");
    end

    // R6: out-of-range index reads zero and does not alias
    set_ptr(2, 64 + 5);
    wr(4'd1, 32'hDEAD_BEEF, 4'hF);
    rd(4'd1, "R6 oob read zero");
    set_ptr(2, 12'hFFF);
    wr(4'd1, 32'hCAFE_F00D, 4'hF);
    rd(4'd1, "R6 top index zero");
    set_ptr(2, 5);
    rd(4'd1, "R6 no alias to idx5");
    set_ptr(2, 63);
    rd(4'd1, "R6 idx63 untouched");
    set_ptr(2, 0);
    rd(4'd1, "R6 idx0 untouched");

    // Fill every entry with a distinct pattern
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 64; i++) begin
        set_ptr(c, i);
        wr(4'd1, {8'(c), 8'(i), 8'(c ^ i), 8'(i * 3)}, 4'hF);
      end

    // R7: a burst of pointer writes, then readback of everything
    for (int k = 0; k < 20; k++) wr(4'd0, 32'h0F3F_0003 ^ (32'(k) * 32'h0011_0001), 4'hF);
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 64; i += 7) begin
        set_ptr(c, i);
        rd(4'd1, "R7 bank kept across ptr writes");
      end

    // R9: unmapped words and idle strobe
    set_ptr(1, 9);
    rd(4'd2, "R9 unmapped read");
    rd(4'd15, "R9 unmapped read top");
    wr(4'd2, 32'hFFFF_FFFF, 4'hF);
    wr(4'd7, 32'h0000_0000, 4'hF);
    rd(4'd0, "R9 ptr unchanged");
    rd(4'd1, "R9 bank unchanged");
    idle();
    @(negedge clk);
    total++;
    if (bus_rdata !== 32'h0) begin
      bad++;
      $display("FAIL R9 idle rdata act=%h exp=%h", bus_rdata, 32'h0);
    end

    // R5: read data follows pointer change with no delay
    set_ptr(3, 10);
    rd(4'd1, "R5 immediate after ptr");
    idle();
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover act=%0d exp=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule